// File: doc/BRIEF.md
# Reference Select and Clock Divider Path

This block is the digital clock path that sits around a two-stage frequency synthesizer. A 2:1 selector picks one of two reference inputs. That reference goes through a pre-divider with six power-of-two ratios and two bypass codes. Two output dividers, each set independently, divide a fast clock by 4, 8 or 32, or park their output in a disabled state that stands for a high-impedance pin.

All state runs on one fast clock. The reference inputs are sampled on that clock, and the pre-divider counts the rising edges of the selected reference. Each ratio other than one is a bit of a free-running binary counter, so every divided output has a 50% duty cycle. When a select code or the reference select changes, the matching counter restarts from zero, so a stale count cannot leave a runt pulse. The two bypass codes do not change the divided clock. They are decoded into two separate control bits that steer a path selection further downstream.

Top module: `clkpath_top`

## Requirements
- R1: With `refSel` = 0 the pre-divider follows `refA`. With `refSel` = 1 it follows `refB`. The reference that is not selected has no effect on `preClk`.
- R2: Pre-divider codes 0..5 on `preSel` give a ratio of 2^code. Code 0 passes the selected reference combinationally to `preClk`. For codes 1..5, `preClk` equals bit (code-1) of a 5-bit counter that adds one on each sampled rising edge of the selected reference. A rising edge is the reference high in a cycle after it was low in the previous cycle.
- R3: `preSel` = 6 raises `bypassClean` alone. `preSel` = 7 raises both `bypassClean` and `bypassMult`. Both codes pass the selected reference unchanged to `preClk`. All other codes hold both bypass bits low.
- R4: An output select code of 0 holds that output's clock low and its enable low.
- R5: Output select codes 1, 2 and 3 divide the fast clock by 32, 8 and 4, with the enable high. The clock equals bit 4, 2 or 1 of a 5-bit counter that adds one every cycle.
- R6: Output A and output B are set only by `outSelA` and `outSelB` respectively. A change on one does not disturb the other.
- R7: In the first cycle a select value differs from the value registered the cycle before, the matching counter is cleared instead of advanced. For the pre-divider this applies to `preSel` or `refSel`; for an output it applies to that output's select. The divided output is therefore low in the next cycle.
- R8: While `rstN` is low all counters and registered selects are zero, so every divided clock is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock for all counters and sampling |
| rstN | input | 1 | Active-low synchronous reset |
| refA | input | 1 | Reference input 0 |
| refB | input | 1 | Reference input 1 |
| refSel | input | 1 | Reference select, 0 = refA, 1 = refB |
| preSel | input | 3 | Pre-divider code (0..5 ratio, 6/7 bypass) |
| outSelA | input | 2 | Output A code (0 off, 1 /32, 2 /8, 3 /4) |
| outSelB | input | 2 | Output B code (0 off, 1 /32, 2 /8, 3 /4) |
| preClk | output | 1 | Divided or passed-through reference |
| bypassClean | output | 1 | Bypass of the first PLL stage requested |
| bypassMult | output | 1 | Bypass of both PLL stages requested |
| outClkA | output | 1 | Output A divided clock |
| outEnA | output | 1 | Output A driven (low = high impedance) |
| outClkB | output | 1 | Output B divided clock |
| outEnB | output | 1 | Output B driven (low = high impedance) |

## Verification
The bench changes select codes in bursts only a few cycles apart, so the restart on a code change is exercised at every counter phase. A design that kept its stale count would emit a short pulse that the per-cycle comparison catches. It toggles the reference select while the pre-divider is mid-count, which exposes a design that restarts only on `preSel` edits or that counts a false rising edge from the mux switching between references of different levels. It also sweeps every pairing of the two output codes, including the non-monotonic mapping and code 0, which catches swapped ratios, a disabled output that still toggles, and coupling between the two outputs.

// File: rtl/clkpath_pkg.sv
package clkpath_pkg;
  localparam int NUM_OUT   = 2;
  localparam int PRE_SEL_W = 3;
  localparam int OUT_SEL_W = 2;
  localparam int PRE_CNT_W = 5;
  localparam int OUT_CNT_W = 5;
  localparam int BIT_W     = $clog2(PRE_CNT_W > OUT_CNT_W ? PRE_CNT_W : OUT_CNT_W);
  localparam logic [PRE_SEL_W-1:0] PRE_MAX_DIV = 3'd5;

  typedef struct packed {
    logic                           preRestart;
    logic                           prePass;
    logic [BIT_W-1:0]               preBit;
    logic [NUM_OUT-1:0]             outRestart;
    logic [NUM_OUT-1:0]             outEn;
    logic [NUM_OUT-1:0][BIT_W-1:0]  outBit;
  } pathCtl_t;

  function automatic logic [BIT_W-1:0] outBitOf(input logic [OUT_SEL_W-1:0] code);
    case (code)
      2'd1:    return BIT_W'(4);
      2'd2:    return BIT_W'(2);
      2'd3:    return BIT_W'(1);
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/clkpath_ctrl.sv
module clkpath_ctrl
  import clkpath_pkg::*;
(
  input  logic                                clk,
  input  logic                                rstN,
  input  logic                                refSel,
  input  logic [PRE_SEL_W-1:0]                preSel,
  input  logic [NUM_OUT-1:0][OUT_SEL_W-1:0]   outSel,
  output pathCtl_t                            ctl,
  output logic                                bypassClean,
  output logic                                bypassMult
);
  logic                              refSelQ;
  logic [PRE_SEL_W-1:0]              preSelQ;
  logic [NUM_OUT-1:0][OUT_SEL_W-1:0] outSelQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      refSelQ <= 1'b0;
      preSelQ <= '0;
      outSelQ <= '0;
    end else begin
      refSelQ <= refSel;
      preSelQ <= preSel;
      outSelQ <= outSel;
    end
  end

  always_comb begin
    ctl = '0;
    ctl.preRestart = (preSel != preSelQ) || (refSel != refSelQ);
    ctl.prePass    = (preSel == '0) || (preSel > PRE_MAX_DIV);
    ctl.preBit     = ctl.prePass ? '0 : BIT_W'(preSel - 1'b1);
    for (int i = 0; i < NUM_OUT; i++) begin
      ctl.outRestart[i] = (outSel[i] != outSelQ[i]);
      ctl.outEn[i]      = |outSel[i];
      ctl.outBit[i]     = outBitOf(outSel[i]);
    end
  end

  assign bypassClean = preSel[2] & preSel[1];
  assign bypassMult  = &preSel;
endmodule

// File: rtl/clkpath_dp.sv
module clkpath_dp
  import clkpath_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               refA,
  input  logic               refB,
  input  logic               refSel,
  input  pathCtl_t           ctl,
  output logic               preClk,
  output logic [NUM_OUT-1:0] outClk
);
  logic                 selRef;
  logic                 refPrev;
  logic                 refRise;
  logic [PRE_CNT_W-1:0] preCnt;

  assign selRef  = refSel ? refB : refA;
  assign refRise = selRef & ~refPrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      refPrev <= 1'b0;
      preCnt  <= '0;
    end else begin
      refPrev <= selRef;
      if (ctl.preRestart)  preCnt <= '0;
      else if (refRise)    preCnt <= preCnt + 1'b1;
    end
  end

  assign preClk = ctl.prePass ? selRef : preCnt[ctl.preBit];

  // R7
  pre_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.preRestart |=> (preCnt == '0));

  // R2
  pre_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!refRise && !ctl.preRestart) |=> $stable(preCnt));

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
    logic [OUT_CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
      if (!rstN)                  cnt <= '0;
      else if (ctl.outRestart[g]) cnt <= '0;
      else                        cnt <= cnt + 1'b1;
    end

    assign outClk[g] = ctl.outEn[g] & cnt[ctl.outBit[g]];

    // R4
    off_low_chk: assert property (@(posedge clk) disable iff (!rstN)
      !ctl.outEn[g] |-> !outClk[g]);

    // R7
    out_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
      ctl.outRestart[g] |=> !outClk[g]);
  end
endmodule

// File: rtl/clkpath_top.sv
module clkpath_top
  import clkpath_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 refA,
  input  logic                 refB,
  input  logic                 refSel,
  input  logic [PRE_SEL_W-1:0] preSel,
  input  logic [OUT_SEL_W-1:0] outSelA,
  input  logic [OUT_SEL_W-1:0] outSelB,
  output logic                 preClk,
  output logic                 bypassClean,
  output logic                 bypassMult,
  output logic                 outClkA,
  output logic                 outEnA,
  output logic                 outClkB,
  output logic                 outEnB
);
  pathCtl_t                          ctl;
  logic [NUM_OUT-1:0][OUT_SEL_W-1:0] outSel;
  logic [NUM_OUT-1:0]                outClk;

  assign outSel = {outSelB, outSelA};

  clkpath_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .refSel(refSel), .preSel(preSel), .outSel(outSel),
    .ctl(ctl), .bypassClean(bypassClean), .bypassMult(bypassMult)
  );

  clkpath_dp u_dp (
    .clk(clk), .rstN(rstN), .refA(refA), .refB(refB), .refSel(refSel),
    .ctl(ctl), .preClk(preClk), .outClk(outClk)
  );

  assign outClkA = outClk[0];
  assign outClkB = outClk[1];
  assign outEnA  = ctl.outEn[0];
  assign outEnB  = ctl.outEn[1];

  // R3
  bypass_nest_chk: assert property (@(posedge clk) disable iff (!rstN)
    bypassMult |-> bypassClean);
endmodule

// File: tb/clkpath_top_tb_top.sv
`timescale 1ns/1ps
module clkpath_top_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       refA = 1'b0, refB = 1'b0, refSel = 1'b0;
  logic [2:0] preSel = 3'd1;
  logic [1:0] outSelA = 2'd0, outSelB = 2'd0;
  logic       preClk, bypassClean, bypassMult, outClkA, outEnA, outClkB, outEnB;

  int checks = 0, fails = 0;
  bit done = 0;
  bit inReset = 1;
  bit freezeB = 0;
  int tick = 0;

  int mPreCnt = 0, mOutCnt[2] = '{0, 0};
  bit mRefPrev = 0, mRefSelQ = 0;
  int mPreSelQ = 0, mOutSelQ[2] = '{0, 0};
  bit mPreRst = 0, mOutRst[2] = '{0, 0};

  always #2 clk = ~clk;

  clkpath_top dut_i (
    .clk(clk), .rstN(rstN), .refA(refA), .refB(refB), .refSel(refSel),
    .preSel(preSel), .outSelA(outSelA), .outSelB(outSelB),
    .preClk(preClk), .bypassClean(bypassClean), .bypassMult(bypassMult),
    .outClkA(outClkA), .outEnA(outEnA), .outClkB(outClkB), .outEnB(outEnB)
  );

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic int outCode(input int i);
    return (i == 0) ? int'(outSelA) : int'(outSelB);
  endfunction

  task automatic modelStep();
    bit sel;
    bit rise;
    sel  = refSel ? refB : refA;
    rise = sel && !mRefPrev;
    mPreRst = (int'(preSel) != mPreSelQ) || (refSel != mRefSelQ);
    if (mPreRst) mPreCnt = 0;
    else if (rise) mPreCnt = (mPreCnt + 1) % 32;
    mRefPrev = sel; mRefSelQ = refSel; mPreSelQ = int'(preSel);
    for (int i = 0; i < 2; i++) begin
      mOutRst[i] = (outCode(i) != mOutSelQ[i]);
      if (mOutRst[i]) mOutCnt[i] = 0;
      else mOutCnt[i] = (mOutCnt[i] + 1) % 32;
      mOutSelQ[i] = outCode(i);
    end
  endtask

  task automatic compareAll();
    int  code;
    int  bitIdx;
    bit  expPre;
    bit  expEn;
    bit  expClk;
    bit  sel;
    string tag;
    sel = refSel ? refB : refA;
    code = int'(preSel);
    if (code == 0 || code >= 6) expPre = sel;
    else expPre = ((mPreCnt >> (code - 1)) % 2) == 1;
    if (inReset) tag = "R8";
    else if (mPreRst) tag = "R7";
    else if (code >= 6) tag = "R3";
    else if (code == 0) tag = "R1";
    else tag = "R2";
    check(tag, "preClk", preClk, expPre);
    check("R3", "bypassClean", bypassClean, code >= 6);
    check("R3", "bypassMult", bypassMult, code == 7);
    for (int i = 0; i < 2; i++) begin
      code = outCode(i);
      expEn = code != 0;
      bitIdx = (code == 1) ? 4 : (code == 2) ? 2 : 1;
      expClk = expEn && (((mOutCnt[i] >> bitIdx) % 2) == 1);
      if (inReset) tag = "R8";
      else if (mOutRst[i]) tag = "R7";
      else if (code == 0) tag = "R4";
      else if (i == 1) tag = "R6";
      else tag = "R5";
      check(tag, (i == 0) ? "outClkA" : "outClkB", (i == 0) ? outClkA : outClkB, expClk);
      check(code == 0 ? "R4" : "R5", (i == 0) ? "outEnA" : "outEnB",
            (i == 0) ? outEnA : outEnB, expEn);
    end
  endtask

  task automatic cycle();
    @(posedge clk);
    if (!inReset) modelStep();
    #1;
    compareAll();
    #1;
    tick++;
    if (tick % 3 == 0) refA = ~refA;
    if (tick % 5 == 0 && !freezeB) refB = ~refB;
  endtask

  initial begin
    repeat (4) cycle();
    rstN = 1'b1; inReset = 0;
    // R1 R2 R3 R4 R5 R6: sweep every pre code, ref select and output pairing
    for (int p = 0; p < 16; p++) begin
      preSel  = 3'(p / 2);
      refSel  = p[0];
      outSelA = 2'(p % 4);
      outSelB = 2'((p / 4) % 4);
      repeat (700) cycle();
    end
    // R7: rapid select changes at arbitrary counter phases
    for (int k = 0; k < 150; k++) begin
      int v;
      v = $urandom;
      preSel  = 3'(v % 8);
      refSel  = v[8];
      outSelA = 2'((v >> 4) % 4);
      outSelB = 2'((v >> 12) % 4);
      repeat (1 + (v >> 20) % 6) cycle();
    end
    // R1: unselected reference frozen, then selected reference frozen
    preSel = 3'd1; refSel = 1'b0; freezeB = 1;
    repeat (200) cycle();
    refSel = 1'b1;
    repeat (200) cycle();
    freezeB = 0;
    // R6: only output B changes while A runs
    outSelA = 2'd3; outSelB = 2'd1;
    repeat (100) cycle();
    outSelB = 2'd0; repeat (50) cycle();
    outSelB = 2'd2; repeat (100) cycle();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired before the test completed");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule